// File: doc/BRIEF.md
# Integer Multiply-Divide Unit with Status Flags

This unit performs 32-bit integer multiplication and division for a processor core. Five operations are supported: signed multiply, unsigned multiply, signed multiply by a sign-extended 16-bit immediate, signed divide and unsigned divide. A one-cycle `start_i` strobe launches an operation. The unit then reports completion on `done_o`, gives the destination value on `result_o`, and asserts `wr_en_o` when the destination is to be written.

Two sticky status flags, overflow and carry, are held inside the unit. They survive between operations. Signed operations act only on the overflow flag and unsigned operations act only on the carry flag. A range exception pulse is raised together with `done_o` when the flag the operation owns ends up set and the exception enable is on. Multiplies finish in one cycle. Division is iterative and takes a setup cycle plus one cycle per quotient bit. While a division is running, new starts are dropped.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, `result_o` is 0 and `done_o`, `wr_en_o`, `ov_o`, `cy_o` and `range_exc_o` are all 0.
- R2: Operation code 0x6 is signed multiply. `done_o` and `wr_en_o` are high in the cycle after the start edge, and `result_o` holds the low 32 bits of the product.
- R3: A signed multiply sets `ov_o` exactly when the true signed product lies outside the signed 32-bit range. It leaves `cy_o` unchanged.
- R4: Operation code 0xB is unsigned multiply. It writes the low 32 bits of the product and sets `cy_o` exactly when the product is 2^32 or more. It leaves `ov_o` unchanged.
- R5: Operation code 0x3 multiplies `a_i` by `imm_i` sign-extended to 32 bits. It follows the signed rule of R3 and changes only `ov_o`.
- R6: Operation code 0x9 with a nonzero divisor is signed divide. The quotient is truncated toward zero. `ov_o` is cleared, `cy_o` is unchanged, and `done_o` and `wr_en_o` go high 33 rising edges after the start edge, counting the start edge as the first.
- R7: Operation code 0xA with a nonzero divisor is unsigned divide. It writes the unsigned quotient, clears `cy_o`, leaves `ov_o` unchanged, and uses the same latency as R6.
- R8: A zero divisor completes one cycle after the start with `wr_en_o` low and `result_o` unchanged. A signed divide sets `ov_o` and an unsigned divide sets `cy_o`.
- R9: Signed division of 0x80000000 by 0xFFFFFFFF writes 0x80000000 and leaves `ov_o` at 0.
- R10: `range_exc_o` pulses together with `done_o` exactly when the flag the operation owns is set by it and `ov_exc_en_i` was 1 at the start edge. Signed operations own overflow and unsigned operations own carry.
- R11: A start that arrives while a division is in progress has no effect. No extra `done_o` appears and the division result is unaffected.
- R12: A start with any other operation code produces no `done_o` and changes neither `result_o` nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle operation launch strobe |
| op_i | input | 4 | Operation code |
| a_i | input | 32 | First operand / dividend |
| b_i | input | 32 | Second operand / divisor |
| imm_i | input | 16 | Immediate for multiply-by-immediate |
| ov_exc_en_i | input | 1 | Range exception enable |
| result_o | output | 32 | Destination value |
| wr_en_o | output | 1 | Destination write pulse |
| ov_o | output | 1 | Overflow flag |
| cy_o | output | 1 | Carry flag |
| range_exc_o | output | 1 | Range exception pulse |
| done_o | output | 1 | Operation complete pulse |

## Verification
The bench concentrates on these corner cases:
- Signed products at the edge of the 32-bit range. A design that checks only the upper word would miss negative products that wrap.
- Unsigned products that only just reach 2^32. A design that looks at the signed result instead would get these wrong.
- Operations that must leave the flag they do not own untouched. A design that clears both flags fails here.
- Zero divisors. A design that writes the destination anyway, or raises the wrong flag for the signedness, fails here.
- The most negative value divided by minus one, and mixed-sign quotients. A design that rounds toward minus infinity would give the wrong quotient. A design that flags the wraparound as overflow would set `ov_o`.
- A start issued in the middle of a division. A design that accepts it would cut the division short or produce an early or extra completion pulse.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;
  typedef enum logic [3:0] {
    OP_MULI = 4'h3,
    OP_MUL  = 4'h6,
    OP_DIV  = 4'h9,
    OP_DIVU = 4'hA,
    OP_MULU = 4'hB
  } op_e;
endpackage

// File: rtl/muldiv_mul.sv
module muldiv_mul #(
  parameter int W = 32
) (
  input  logic         signed_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] lo_o,
  output logic         wrap_o
);
  logic signed [W:0]     ea, eb;
  logic signed [2*W+1:0] prod;
  logic [W+2:0]          hi_s;

  assign ea   = $signed({signed_i & a_i[W-1], a_i});
  assign eb   = $signed({signed_i & b_i[W-1], b_i});
  assign prod = ea * eb;
  assign lo_o = prod[W-1:0];
  // signed fit: all bits from W-1 upward equal
  assign hi_s = prod[2*W+1:W-1];
  assign wrap_o = signed_i ? !((&hi_s) || !(|hi_s)) : (|prod[2*W-1:W]);
endmodule

// File: rtl/muldiv_div.sv
module muldiv_div #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         signed_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         busy_o,
  output logic         fin_o,
  output logic [W-1:0] quo_o
);
  localparam int CW = $clog2(W);

  logic [CW-1:0] cnt_q;
  logic [W-1:0]  rem_q, quo_q, dvs_q, rem_n, quo_n;
  logic          busy_q, neg_q, ge;
  logic [W:0]    shifted, diff;

  assign shifted = {rem_q, quo_q[W-1]};
  assign diff    = shifted - {1'b0, dvs_q};
  assign ge      = !diff[W];
  assign rem_n   = ge ? diff[W-1:0] : shifted[W-1:0];
  assign quo_n   = {quo_q[W-2:0], ge};

  assign busy_o = busy_q;
  assign fin_o  = busy_q && (cnt_q == CW'(W-1));
  assign quo_o  = neg_q ? (~quo_n + 1'b1) : quo_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      neg_q  <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
    end else if (busy_q) begin
      rem_q <= rem_n;
      quo_q <= quo_n;
      cnt_q <= cnt_q + 1'b1;
      if (fin_o) busy_q <= 1'b0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      rem_q  <= '0;
      neg_q  <= signed_i && (a_i[W-1] ^ b_i[W-1]);
      quo_q  <= (signed_i && a_i[W-1]) ? (~a_i + 1'b1) : a_i;
      dvs_q  <= (signed_i && b_i[W-1]) ? (~b_i + 1'b1) : b_i;
    end
  end
endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int W  = 32,
  parameter int IW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [3:0]    op_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [IW-1:0] imm_i,
  input  logic          ov_exc_en_i,
  output logic [W-1:0]  result_o,
  output logic          wr_en_o,
  output logic          ov_o,
  output logic          cy_o,
  output logic          range_exc_o,
  output logic          done_o
);
  import muldiv_pkg::*;

  op_e          op;
  logic         accept, is_div, div_go, div_busy, div_fin, mul_wrap;
  logic [W-1:0] mul_b, mul_lo, div_quo;
  logic         sgn_q;

  assign op     = op_e'(op_i);
  assign accept = start_i && !div_busy;
  assign is_div = (op == OP_DIV) || (op == OP_DIVU);
  assign div_go = accept && is_div && (b_i != '0);
  assign mul_b  = (op == OP_MULI) ? {{(W-IW){imm_i[IW-1]}}, imm_i} : b_i;

  muldiv_mul #(.W(W)) u_mul (
    .signed_i (op != OP_MULU),
    .a_i      (a_i),
    .b_i      (mul_b),
    .lo_o     (mul_lo),
    .wrap_o   (mul_wrap)
  );

  muldiv_div #(.W(W)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (div_go),
    .signed_i (op == OP_DIV),
    .a_i      (a_i),
    .b_i      (b_i),
    .busy_o   (div_busy),
    .fin_o    (div_fin),
    .quo_o    (div_quo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o    <= '0;
      wr_en_o     <= 1'b0;
      ov_o        <= 1'b0;
      cy_o        <= 1'b0;
      range_exc_o <= 1'b0;
      done_o      <= 1'b0;
      sgn_q       <= 1'b0;
    end else begin
      wr_en_o     <= 1'b0;
      range_exc_o <= 1'b0;
      done_o      <= 1'b0;
      if (div_fin) begin
        result_o <= div_quo;
        wr_en_o  <= 1'b1;
        done_o   <= 1'b1;
        if (sgn_q) ov_o <= 1'b0;
        else       cy_o <= 1'b0;
      end else if (accept) begin
        unique case (op)
          OP_MUL, OP_MULI: begin
            result_o    <= mul_lo;
            wr_en_o     <= 1'b1;
            done_o      <= 1'b1;
            ov_o        <= mul_wrap;
            range_exc_o <= mul_wrap && ov_exc_en_i;
          end
          OP_MULU: begin
            result_o    <= mul_lo;
            wr_en_o     <= 1'b1;
            done_o      <= 1'b1;
            cy_o        <= mul_wrap;
            range_exc_o <= mul_wrap && ov_exc_en_i;
          end
          OP_DIV, OP_DIVU: begin
            sgn_q <= (op == OP_DIV);
            if (b_i == '0) begin
              done_o      <= 1'b1;
              range_exc_o <= ov_exc_en_i;
              if (op == OP_DIV) ov_o <= 1'b1;
              else              cy_o <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic [3:0]   op_i,
  input logic [W-1:0] b_i,
  input logic         div_busy,
  input logic         wr_en_o,
  input logic         ov_o,
  input logic         cy_o,
  input logic         range_exc_o,
  input logic         done_o
);
  logic go;
  assign go = start_i && !div_busy;

  a_r2_mul_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && op_i == 4'h6) |=> (done_o && wr_en_o));
  a_r3_mul_keeps_cy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && op_i == 4'h6) |=> $stable(cy_o));
  a_r4_mulu_keeps_ov: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && op_i == 4'hB) |=> $stable(ov_o));
  a_r8_zero_div_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && op_i == 4'h9 && b_i == '0) |=> (ov_o && done_o && !wr_en_o));
  a_r10_exc_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    range_exc_o |-> (done_o && (ov_o || cy_o)));
  a_r11_no_done_mid_div: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_busy && $past(div_busy) && !$past(done_o)) |-> !done_o);
  a_r12_bad_op_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && !(op_i inside {4'h3, 4'h6, 4'h9, 4'hA, 4'hB})) |=> !done_o);
endmodule

bind muldiv_unit muldiv_unit_chk #(.W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .op_i        (op_i),
  .b_i         (b_i),
  .div_busy    (div_busy),
  .wr_en_o     (wr_en_o),
  .ov_o        (ov_o),
  .cy_o        (cy_o),
  .range_exc_o (range_exc_o),
  .done_o      (done_o)
);

// File: tb/muldiv_unit_tb_top.sv
`timescale 1ns/1ps
module muldiv_unit_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0, en = 1'b0;
  logic [3:0]  op = 4'h0;
  logic [31:0] a = '0, b = '0;
  logic [15:0] imm = '0;
  logic [31:0] result;
  logic        wr_en, ov, cy, exc, done;
  int checks = 0, errors = 0;

  logic [31:0] m_res;
  logic        m_ov, m_cy;

  always #10 clk = ~clk;

  muldiv_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .a_i(a), .b_i(b),
    .imm_i(imm), .ov_exc_en_i(en), .result_o(result), .wr_en_o(wr_en),
    .ov_o(ov), .cy_o(cy), .range_exc_o(exc), .done_o(done)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic launch(logic [3:0] o, logic [31:0] x, logic [31:0] y, logic [15:0] im, logic e);
    @(negedge clk);
    op = o; a = x; b = y; imm = im; en = e; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  // run one operation and compare against the reference model
  task automatic run(string req, logic [3:0] o, logic [31:0] x, logic [31:0] y,
                     logic [15:0] im, logic e);
    longint p;
    logic [63:0] pu;
    logic [31:0] yy;
    logic e_wr, e_exc;
    int e_lat, lat;
    e_wr = 1'b1; e_exc = 1'b0; e_lat = 1;
    yy = (o == 4'h3) ? {{16{im[15]}}, im} : y;
    case (o)
      4'h6, 4'h3: begin
        p = longint'($signed(x)) * longint'($signed(yy));
        m_res = p[31:0];
        m_ov = (p < -64'sd2147483648) || (p > 64'sd2147483647);
        e_exc = m_ov && e;
      end
      4'hB: begin
        pu = {32'd0, x} * {32'd0, y};
        m_res = pu[31:0];
        m_cy = |pu[63:32];
        e_exc = m_cy && e;
      end
      4'h9: if (y == 0) begin
        m_ov = 1'b1; e_wr = 1'b0; e_exc = e;
      end else begin
        p = longint'($signed(x)) / longint'($signed(y));
        m_res = p[31:0]; m_ov = 1'b0; e_lat = 33;
      end
      default: if (y == 0) begin
        m_cy = 1'b1; e_wr = 1'b0; e_exc = e;
      end else begin
        m_res = x / y; m_cy = 1'b0; e_lat = 33;
      end
    endcase
    launch(o, x, y, im, e);
    wait_done(lat);
    chk({req, " latency"}, lat, e_lat);
    chk({req, " result"}, result, m_res);
    chk({req, " wr_en"}, wr_en, e_wr);
    chk({req, " ov"}, ov, m_ov);
    chk({req, " cy"}, cy, m_cy);
    chk({req, " exc"}, exc, e_exc);
    @(negedge clk);
    chk({req, " done pulse"}, done, 1'b0);
  endtask

  task automatic t_reset();
    chk("R1 result", result, 0);
    chk("R1 outs", {done, wr_en, ov, cy, exc}, 0);
    m_res = '0; m_ov = 1'b0; m_cy = 1'b0;
  endtask

  task automatic t_busy();
    int lat;
    launch(4'h9, 32'd100, 32'd7, 16'd0, 1'b0);
    repeat (4) @(negedge clk);
    start = 1'b1; op = 4'h6; a = 32'd3; b = 32'd3;
    @(negedge clk);
    start = 1'b0;
    lat = 6;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    chk("R11 latency", lat, 33);
    chk("R11 result", result, 32'd14);
    repeat (3) @(negedge clk);
    chk("R11 no extra done", {done, result}, {1'b0, 32'd14});
    m_res = 32'd14; m_ov = 1'b0;
  endtask

  task automatic t_badop();
    logic seen;
    seen = 1'b0;
    launch(4'h0, 32'd5, 32'd5, 16'd0, 1'b1);
    repeat (3) begin
      seen |= done;
      @(negedge clk);
    end
    chk("R12 no done", seen, 1'b0);
    chk("R12 state", {result, ov, cy}, {m_res, m_ov, m_cy});
  endtask

  initial begin
    #(20ns * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    run("R2", 4'h6, 32'd1234, 32'd5678, 16'd0, 1'b0);
    run("R2", 4'h6, 32'hFFFF_FFFD, 32'd7, 16'd0, 1'b0);
    run("R3", 4'h6, 32'h0001_0000, 32'h0000_8000, 16'd0, 1'b0);
    run("R3", 4'h6, 32'hFFFF_0000, 32'h0000_8000, 16'd0, 1'b0);
    run("R3", 4'h6, 32'hFFFF_0000, 32'h0000_8001, 16'd0, 1'b0);
    run("R4", 4'hB, 32'hFFFF_FFFF, 32'd1, 16'd0, 1'b0);
    run("R4", 4'hB, 32'h0001_0000, 32'h0001_0000, 16'd0, 1'b0);
    run("R4", 4'hB, 32'h0000_FFFF, 32'h0001_0001, 16'd0, 1'b0);
    run("R5", 4'h3, 32'd1000, 32'd0, 16'hFFF6, 1'b0);
    run("R5", 4'h3, 32'h4000_0000, 32'd0, 16'h0002, 1'b0);
    run("R6", 4'h9, 32'hFFFF_FFF9, 32'd2, 16'd0, 1'b0);
    run("R6", 4'h9, 32'd7, 32'hFFFF_FFFE, 16'd0, 1'b0);
    run("R7", 4'hA, 32'hFFFF_FFF9, 32'd2, 16'd0, 1'b0);
    run("R7", 4'hA, 32'hDEAD_BEEF, 32'h0001_0003, 16'd0, 1'b0);
    run("R8", 4'h9, 32'd55, 32'd0, 16'd0, 1'b0);
    run("R8", 4'hA, 32'd55, 32'd0, 16'd0, 1'b0);
    run("R9", 4'h9, 32'h8000_0000, 32'hFFFF_FFFF, 16'd0, 1'b0);
    run("R10", 4'h6, 32'h7FFF_FFFF, 32'd2, 16'd0, 1'b1);
    run("R10", 4'hB, 32'hFFFF_FFFF, 32'd2, 16'd0, 1'b1);
    run("R10", 4'hA, 32'd9, 32'd0, 16'd0, 1'b1);
    run("R10", 4'h6, 32'd3, 32'd4, 16'd0, 1'b1);
    t_busy();
    t_badop();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule